// File: doc/BRIEF.md
# Prioritised Interrupt Entry and Return Sequencer

This block sits beside the execute unit of a small 8-bit processor and owns everything that happens between two instructions when an interrupt is taken. It keeps the interrupt status word, latching pulses from eight external request lines and from the software interrupt instruction. At every instruction boundary the CPU offers, it ANDs the mask with the status, picks the lowest-numbered pending line and, if interrupts are enabled, takes over the memory and register ports. It then pushes the machine context onto the stack and jumps to the handler whose address sits in a table at the top of memory.

The return instruction hands control back to the block, which unwinds the same frame in reverse and enables interrupts again. While the block works it raises `busy`, and the CPU must not fetch. The stack pointer and the register file live outside the block. The block reads them through a read port and writes them through a single write port. Memory is read combinationally: `mem_rdata` reflects `mem_addr` in the same cycle.

The status word is held inside this block and is presented on `is_o`, which the CPU reads wherever software reads register 6. Line 0 is wired to the one-second timer. Line 1 is wired to the keyboard, whose key code software reads at address 0xF4.

Top module: `irq_entry_seq`

## Requirements
- R1: Each cycle, every bit set on `irq_lines`, and bit `int_num` when `int_req` is high, is ORed into the status word `is_o` on the next clock edge. Bits latched while interrupts are disabled are kept.
- R2: An interrupt is taken only in a cycle where the block is idle, `boundary` is high, `iret_req` is low, `ien` is high and `im & is_o` is non-zero. The lowest set bit of that AND wins. `busy` is high in that cycle. If no interrupt is taken, the block writes nothing and `busy` stays low.
- R3: On acceptance, the winning status bit is cleared and `ien` drops on the next edge. A request for the same bit arriving in the acceptance cycle is kept, because setting wins over clearing.
- R4: Starting from `sp_i`, nine pre-decrement pushes write the following values. Address SP-1 gets `pc_i`. Address SP-2 gets `fl_i`. Addresses SP-3 down to SP-8 get registers 0 to 5. Address SP-9 gets the current status word, in the slot of register 6.
- R5: After the pushes, one more cycle loads the PC from memory address 0xF8 plus the winning line number and writes SP-9 to register 7. `busy` stays high for 11 cycles in total, counting the acceptance cycle.
- R6: From the acceptance edge until the return sequence completes, `ien` is low and `boundary` is ignored.
- R7: `iret_req` in an idle cycle starts nine post-increment pops. The first pop is the register 6 slot, which is read and discarded so that latched requests survive. The next six pops restore registers 5 down to 0. Then FL is restored, then PC. In the PC cycle, register 7 receives the final SP. `ien` rises after that cycle. `busy` is high for 10 cycles.
- R8: After reset, the status word is 0, `ien` is 1, `busy` is 0 and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 8 | External request pulses, one per line |
| int_req | input | 1 | Software interrupt instruction executing |
| int_num | input | 3 | Line number raised by the software interrupt |
| iret_req | input | 1 | Return-from-interrupt instruction executing |
| boundary | input | 1 | CPU is between instructions and about to fetch |
| im | input | 8 | Interrupt mask (register 5) |
| pc_i | input | 8 | Address of the next instruction |
| fl_i | input | 8 | Current flags |
| sp_i | input | 8 | Current stack pointer (register 7) |
| reg_raddr | output | 3 | Register file read address |
| reg_rdata | input | 8 | Register file read data |
| reg_we | output | 1 | Register file write enable |
| reg_waddr | output | 3 | Register file write address |
| reg_wdata | output | 8 | Register file write data |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, combinational on mem_addr |
| pc_we | output | 1 | PC load enable |
| pc_wdata | output | 8 | PC load value |
| fl_we | output | 1 | Flags load enable |
| fl_wdata | output | 8 | Flags load value |
| busy | output | 1 | Sequence in progress; CPU must not fetch |
| ien | output | 1 | Interrupts globally enabled |
| is_o | output | 8 | Interrupt status word (register 6 view) |

## Verification
The assertions assume that the CPU holds `pc_i`, `fl_i` and `sp_i` steady while `busy` is high, and that it raises `iret_req` only while `ien` is low, that is, from inside a handler. The stimulus meets both assumptions. It changes the CPU-side registers only while the block is idle, and it issues a return only after an entry has completed. No external request arrives during a push burst, so the saved status slot has one known value. Any same-cycle collision between a set and a clear is placed on the acceptance cycle, where R3 defines the result.

// File: rtl/irq_seq_pkg.sv
// Package: shared state encoding for the interrupt entry/return sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_VEC  = 2'd2,
        ST_POP  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/irq_prio_pick.sv
// Lowest-index-first picker: grants the lowest set bit of req and encodes it.
// Assumes: N >= 2. Purely combinational.
module irq_prio_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    logic [N:0] below;

    assign below[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign below[g+1] = below[g] | req[g];
            assign grant[g]   = req[g] & ~below[g];
        end
    endgenerate

    assign any = below[N];

    // Encode the one-hot grant as a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
// Interrupt status word: clear mask applied first, then set mask ORed in,
// so a new request wins over a same-cycle clear.
// Assumes: synchronous active-low reset.
module irq_status_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status
);
    // Hold pending requests until serviced.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/irq_frame_fsm.sv
// Frame sequencer: pushes the context frame and loads the vector on entry,
// pops the frame on return, and owns the global interrupt enable.
// Assumes: combinational memory read; CPU holds pc/fl/sp stable while busy.
module irq_frame_fsm
    import irq_seq_pkg::*;
#(
    parameter int                DW         = 8,
    parameter int                NIRQ       = 8,
    parameter int                NSAVE      = 7,
    parameter int                STATUS_REG = 6,
    parameter logic [DW-1:0]     VEC_BASE   = 8'hF8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic                       ret_go,
    input  logic [$clog2(NIRQ)-1:0]    win,
    input  logic [NIRQ-1:0]            status,
    input  logic [DW-1:0]              pc_i,
    input  logic [DW-1:0]              fl_i,
    input  logic [DW-1:0]              sp_i,
    output logic [$clog2(NSAVE+1)-1:0] reg_raddr,
    input  logic [DW-1:0]              reg_rdata,
    output logic                       reg_we,
    output logic [$clog2(NSAVE+1)-1:0] reg_waddr,
    output logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              mem_addr,
    output logic                       mem_we,
    output logic [DW-1:0]              mem_wdata,
    input  logic [DW-1:0]              mem_rdata,
    output logic                       pc_we,
    output logic [DW-1:0]              pc_wdata,
    output logic                       fl_we,
    output logic [DW-1:0]              fl_wdata,
    output logic                       idle,
    output logic                       ien
);
    localparam int IW     = $clog2(NIRQ);
    localparam int RW     = $clog2(NSAVE + 1);
    localparam int FRAME  = NSAVE + 2;
    localparam int SW     = $clog2(FRAME + 1);
    localparam int SP_REG = NSAVE;
    localparam logic [SW-1:0] LAST = SW'(FRAME - 1);

    seq_state_t      state;
    logic [SW-1:0]   step;
    logic [DW-1:0]   sp_w;
    logic [IW-1:0]   num;
    logic [DW-1:0]   sp_dn;
    logic [DW-1:0]   sp_up;
    logic [RW-1:0]   push_reg;
    logic [RW-1:0]   pop_reg;

    assign sp_dn    = sp_w - DW'(1);
    assign sp_up    = sp_w + DW'(1);
    assign push_reg = RW'(step - SW'(2));
    assign pop_reg  = RW'(SW'(NSAVE - 1) - step);
    assign idle     = (state == ST_IDLE);

    // Advance the sequence, track the working stack pointer and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
            sp_w  <= '0;
            num   <= '0;
            ien   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    step <= '0;
                    if (ret_go) begin
                        state <= ST_POP;
                        sp_w  <= sp_i;
                    end else if (take) begin
                        state <= ST_PUSH;
                        sp_w  <= sp_i;
                        num   <= win;
                        ien   <= 1'b0;
                    end
                end
                ST_PUSH: begin
                    sp_w <= sp_dn;
                    if (step == LAST) state <= ST_VEC;
                    else              step  <= step + SW'(1);
                end
                ST_VEC: begin
                    state <= ST_IDLE;
                end
                ST_POP: begin
                    sp_w <= sp_up;
                    if (step == LAST) begin
                        state <= ST_IDLE;
                        ien   <= 1'b1;
                    end else begin
                        step <= step + SW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive memory, register file, PC and flag ports for the current step.
    always_comb begin
        reg_raddr = '0;
        reg_we    = 1'b0;
        reg_waddr = '0;
        reg_wdata = '0;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        pc_we     = 1'b0;
        pc_wdata  = '0;
        fl_we     = 1'b0;
        fl_wdata  = '0;
        case (state)
            ST_PUSH: begin
                mem_we   = 1'b1;
                mem_addr = sp_dn;
                if (step == SW'(0)) begin
                    mem_wdata = pc_i;
                end else if (step == SW'(1)) begin
                    mem_wdata = fl_i;
                end else begin
                    reg_raddr = push_reg;
                    if (push_reg == RW'(STATUS_REG)) mem_wdata = DW'(status);
                    else                             mem_wdata = reg_rdata;
                end
            end
            ST_VEC: begin
                mem_addr  = VEC_BASE + DW'(num);
                pc_we     = 1'b1;
                pc_wdata  = mem_rdata;
                reg_we    = 1'b1;
                reg_waddr = RW'(SP_REG);
                reg_wdata = sp_w;
            end
            ST_POP: begin
                mem_addr = sp_w;
                if (step < SW'(NSAVE)) begin
                    if (pop_reg != RW'(STATUS_REG)) begin
                        reg_we    = 1'b1;
                        reg_waddr = pop_reg;
                        reg_wdata = mem_rdata;
                    end
                end else if (step == SW'(NSAVE)) begin
                    fl_we    = 1'b1;
                    fl_wdata = mem_rdata;
                end else begin
                    pc_we     = 1'b1;
                    pc_wdata  = mem_rdata;
                    reg_we    = 1'b1;
                    reg_waddr = RW'(SP_REG);
                    reg_wdata = sp_up;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Top: combines status latching, priority pick and frame sequencing.
// Assumes: boundary/iret_req come from the CPU control unit; the CPU stalls
// fetch while busy is high and presents a stable pc_i/fl_i/sp_i.
module irq_entry_seq #(
    parameter int            DW         = 8,
    parameter int            NIRQ       = 8,
    parameter int            NSAVE      = 7,
    parameter int            STATUS_REG = 6,
    parameter logic [DW-1:0] VEC_BASE   = 8'hF8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NIRQ-1:0]            irq_lines,
    input  logic                       int_req,
    input  logic [$clog2(NIRQ)-1:0]    int_num,
    input  logic                       iret_req,
    input  logic                       boundary,
    input  logic [NIRQ-1:0]            im,
    input  logic [DW-1:0]              pc_i,
    input  logic [DW-1:0]              fl_i,
    input  logic [DW-1:0]              sp_i,
    output logic [$clog2(NSAVE+1)-1:0] reg_raddr,
    input  logic [DW-1:0]              reg_rdata,
    output logic                       reg_we,
    output logic [$clog2(NSAVE+1)-1:0] reg_waddr,
    output logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              mem_addr,
    output logic                       mem_we,
    output logic [DW-1:0]              mem_wdata,
    input  logic [DW-1:0]              mem_rdata,
    output logic                       pc_we,
    output logic [DW-1:0]              pc_wdata,
    output logic                       fl_we,
    output logic [DW-1:0]              fl_wdata,
    output logic                       busy,
    output logic                       ien,
    output logic [NIRQ-1:0]            is_o
);
    localparam int IW = $clog2(NIRQ);

    logic [NIRQ-1:0] pending;
    logic [NIRQ-1:0] grant;
    logic [NIRQ-1:0] set_mask;
    logic [NIRQ-1:0] clr_mask;
    logic [IW-1:0]   win;
    logic            any;
    logic            idle;
    logic            take;
    logic            ret_go;

    assign pending  = im & is_o;
    assign ret_go   = idle & iret_req;
    assign take     = idle & ~iret_req & boundary & ien & any;
    assign clr_mask = take ? grant : '0;
    assign set_mask = irq_lines | (int_req ? (NIRQ'(1) << int_num) : '0);
    assign busy     = ~idle | take | ret_go;

    irq_status_reg #(.N(NIRQ)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .status   (is_o)
    );

    irq_prio_pick #(.N(NIRQ)) u_pick (
        .req   (pending),
        .any   (any),
        .grant (grant),
        .idx   (win)
    );

    irq_frame_fsm #(
        .DW         (DW),
        .NIRQ       (NIRQ),
        .NSAVE      (NSAVE),
        .STATUS_REG (STATUS_REG),
        .VEC_BASE   (VEC_BASE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .ret_go    (ret_go),
        .win       (win),
        .status    (is_o),
        .pc_i      (pc_i),
        .fl_i      (fl_i),
        .sp_i      (sp_i),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .pc_we     (pc_we),
        .pc_wdata  (pc_wdata),
        .fl_we     (fl_we),
        .fl_wdata  (fl_wdata),
        .idle      (idle),
        .ien       (ien)
    );
endmodule

// File: rtl/irq_entry_seq_chk.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
// Assumes: the CPU-side environment described in the brief.
module irq_entry_seq_chk #(
    parameter int NSAVE = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       ien,
    input logic                       mem_we,
    input logic                       reg_we,
    input logic [$clog2(NSAVE+1)-1:0] reg_waddr,
    input logic                       pc_we,
    input logic                       fl_we
);
    localparam int RW = $clog2(NSAVE + 1);

    p_push_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ien);

    p_pc_load_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> busy);

    p_pc_fl_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> !fl_we);

    p_reenable_after_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ien) |-> $past(pc_we));

    p_disable_on_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ien) |-> $past(busy));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !reg_we && !pc_we && !fl_we));

    p_sp_with_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && reg_we) |-> (reg_waddr == RW'(NSAVE)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NSAVE(NSAVE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .ien       (ien),
    .mem_we    (mem_we),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .pc_we     (pc_we),
    .fl_we     (fl_we)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lines = '0;
    logic       int_req = 1'b0;
    logic [2:0] int_num = '0;
    logic       iret_req = 1'b0;
    logic       boundary = 1'b0;
    logic [7:0] im = '0;
    logic [2:0] reg_raddr, reg_waddr;
    logic [7:0] reg_wdata, mem_addr, mem_wdata, pc_wdata, fl_wdata, is_o;
    logic       reg_we, mem_we, pc_we, fl_we, busy, ien;

    logic [7:0] mem [256];
    logic [7:0] regs [8];
    logic [7:0] pc, fl;

    int n_chk = 0;
    int n_fail = 0;
    bit run = 0;

    always #5 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_req(int_req),
        .int_num(int_num), .iret_req(iret_req), .boundary(boundary), .im(im),
        .pc_i(pc), .fl_i(fl), .sp_i(regs[7]), .reg_raddr(reg_raddr),
        .reg_rdata(regs[reg_raddr]), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem[mem_addr]), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .fl_we(fl_we), .fl_wdata(fl_wdata),
        .busy(busy), .ien(ien), .is_o(is_o)
    );

    // CPU-side environment: apply the block's write strobes.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (reg_we) regs[reg_waddr] <= reg_wdata;
        if (pc_we)  pc <= pc_wdata;
        if (fl_we)  fl <= fl_wdata;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: status word, enable and remaining busy cycles.
    logic [7:0] is_m;
    bit         ien_m;
    int         cnt_m;
    bit         ret_mode;

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        logic [7:0] clr;
        int w;
        clr = '0;
        if (!rst_n) begin
            is_m = '0; ien_m = 1; cnt_m = 0; ret_mode = 0;
        end else begin
            w = lowest(im & is_m);
            if (cnt_m == 0) begin
                if (iret_req) begin
                    cnt_m = 9; ret_mode = 1;
                end else if (boundary && ien_m && w >= 0) begin
                    cnt_m = 10; ret_mode = 0; ien_m = 0; clr[w] = 1'b1;
                end
            end else begin
                cnt_m--;
                if (cnt_m == 0 && ret_mode) ien_m = 1;
            end
            is_m = (is_m & ~clr) | irq_lines | (int_req ? (8'd1 << int_num) : 8'd0);
        end
    end

    // Compare against the reference once per cycle, just before the edge.
    always @(negedge clk) begin
        if (run) begin
            bit eb;
            #4;
            eb = (cnt_m != 0) || iret_req ||
                 (boundary && ien_m && ((im & is_m) != 0));
            chk("R2 busy", int'(busy), int'(eb));
            chk("R1 status", int'(is_o), int'(is_m));
            chk("R6 enable", int'(ien), int'(ien_m));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_boundary();
        boundary = 1; @(negedge clk); boundary = 0;
    endtask

    task automatic do_iret();
        iret_req = 1; @(negedge clk); iret_req = 0;
        cyc(11);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) mem[8'hF8 + i] = 8'h40 + 8'(i * 16);
        for (int i = 0; i < 6; i++) regs[i] = 8'h11 * 8'(i + 1);
        regs[6] = '0; regs[7] = 8'hF4;
        pc = 8'h2A; fl = 8'h05;
        cyc(3);
        rst_n = 1;
        @(negedge clk); #1;
        // R8: reset state
        chk("R8 status", int'(is_o), 0);
        chk("R8 enable", int'(ien), 1);
        chk("R8 busy", int'(busy), 0);
        chk("R8 strobes", int'({mem_we, reg_we, pc_we, fl_we}), 0);
        run = 1;
        im = 8'hFF;
        @(negedge clk);
        irq_lines = 8'h28; @(negedge clk); irq_lines = '0;
        #1 chk("R1 latched lines", int'(is_o), 8'h28);
        @(negedge clk);
        // R2: lines 3 and 5 pending, line 3 wins
        pulse_boundary();
        cyc(12);
        chk("R4 PC slot", int'(mem[8'hF3]), 8'h2A);
        chk("R4 FL slot", int'(mem[8'hF2]), 8'h05);
        for (int i = 0; i < 6; i++)
            chk("R4 reg slot", int'(mem[8'hF1 - 8'(i)]), int'(8'h11 * 8'(i + 1)));
        chk("R4 status slot", int'(mem[8'hEB]), 8'h20);
        chk("R5 vector 3", int'(pc), 8'h70);
        chk("R5 SP after entry", int'(regs[7]), 8'hEB);
        chk("R3 winner cleared", int'(is_o), 8'h20);
        // R6: software interrupt latched, boundary ignored while disabled
        int_req = 1; int_num = 3'd0; boundary = 1;
        @(negedge clk);
        int_req = 0; boundary = 0;
        cyc(2);
        chk("R6 pc unchanged", int'(pc), 8'h70);
        chk("R1 INT latched while disabled", int'(is_o), 8'h21);
        for (int i = 0; i < 6; i++) regs[i] = 8'h00;
        fl = 8'h00; pc = 8'h99;
        do_iret();
        // R7: frame restored, status slot discarded
        for (int i = 0; i < 6; i++)
            chk("R7 reg restored", int'(regs[i]), int'(8'h11 * 8'(i + 1)));
        chk("R7 FL restored", int'(fl), 8'h05);
        chk("R7 PC restored", int'(pc), 8'h2A);
        chk("R7 SP restored", int'(regs[7]), 8'hF4);
        chk("R7 status kept", int'(is_o), 8'h21);
        chk("R7 enabled", int'(ien), 1);
        // R2: mask hides line 0, line 5 taken
        im = 8'h20;
        pulse_boundary();
        cyc(12);
        chk("R2 masked pick", int'(pc), 8'h90);
        chk("R4 status slot 2", int'(mem[8'hEB]), 8'h01);
        do_iret();
        chk("R7 PC back", int'(pc), 8'h2A);
        // R2: nothing unmasked, no entry
        im = 8'h00;
        pulse_boundary();
        cyc(3);
        chk("R2 no take", int'(pc), 8'h2A);
        chk("R2 SP untouched", int'(regs[7]), 8'hF4);
        // R3: same-bit request in acceptance cycle survives
        im = 8'hFF;
        boundary = 1; irq_lines = 8'h01;
        @(negedge clk);
        boundary = 0; irq_lines = '0;
        cyc(12);
        chk("R5 vector 0", int'(pc), 8'h40);
        chk("R3 set wins clear", int'(is_o), 8'h01);
        do_iret();
        run = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule